// File: doc/BRIEF.md
# IDE Channel Timing Configuration Window

This block sits beside the task-file port decoder of one IDE channel and guards a small set of timing configuration registers that share the drive's I/O offsets. It observes every host access to the channel (offset, direction, byte or word size, low data byte). Normally all offsets belong to the drive. A fixed unlock handshake switches the channel into a configuration window. Inside the window, several offsets address local registers instead of the drive. A dedicated lock write closes the window again.

The block holds one read-cycle timing byte and one write-cycle timing byte per timing bank, plus a control byte and a miscellaneous byte. It presents all of them as decoded outputs to the drive cycle generator. An index write to the miscellaneous offset picks the bank that the timing offsets reach. Banks other than the first can be reached only after an enabling write made outside the window. A steer output tells the surrounding channel logic to keep window accesses away from the drive.

Top module: `ide_cfg_window`

## Requirements
- R1: After reset every stored byte (all timing banks, control, miscellaneous) is 0, the bank index is 0, the alternate-bank enable is clear, the window is closed and `cfg_steer` is low.
- R2: The window opens when a byte write of 0x03 at offset 2 follows two word reads at offset 1, with no other access in between. An earlier run of more than two such reads also counts. `cfg_steer` is high from the cycle after that write.
- R3: While the window is closed, an access that is not a word read at offset 1 breaks the unlock run. This covers a byte read at offset 1, an access at any other offset, and a write at offset 2 with another value or of word size. A later 0x03 write then does not open the window.
- R4: While the window is open, a byte write of 0x83 at offset 2 closes it, and `cfg_steer` is low from the next cycle. Other writes at offset 2 leave the window open and change no register.
- R5: While the window is open, offset 0 reaches the selected bank's read-cycle timing byte and offset 1 its write-cycle timing byte. Offset 3 reaches the control byte and offset 6 the miscellaneous byte. A write stores the low data byte, and a read returns the stored byte on `acc_rdata` in the same cycle.
- R6: A window write at offset 6 with a value below the bank count (0 = bank A, 1 = bank B) sets the bank index and leaves the miscellaneous byte unchanged. Any larger value is stored as the miscellaneous byte.
- R7: A write with low byte 0xC0 at offset 3 while the window is closed sets the alternate-bank enable, which stays set until reset. Until then, timing accesses reach bank A whatever the bank index.
- R8: Offset 5 reads 0x00 while the window is open, and writes to it have no effect.
- R9: Reads at offsets 2, 4 and 7 inside the window return 0xFF, and every read while the window is closed returns 0xFF.
- R10: While the window is closed, writes change no timing, control or miscellaneous byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A host access to the channel is present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_word | input | 1 | 1 = 16-bit access, 0 = byte access |
| acc_ofs | input | 3 | Offset from the channel base |
| acc_wdata | input | REG_W (8) | Low data byte of a write |
| acc_rdata | output | REG_W (8) | Read data for a steered access |
| cfg_steer | output | 1 | Window open: keep accesses away from the drive |
| rd_timing | output | BANK_CNT*REG_W (16) | Read-cycle timing bytes, bank 0 in the low byte |
| wr_timing | output | BANK_CNT*REG_W (16) | Write-cycle timing bytes, bank 0 in the low byte |
| ctrl_word | output | REG_W (8) | Control byte |
| misc_word | output | REG_W (8) | Miscellaneous byte |

## Verification
The bench builds the block with its defaults: two timing banks, byte-wide registers and key values 0x03, 0x83 and 0xC0. With two banks, the effect of the alternate-bank enable on the bank index can be seen at the ports. Bank B remains untouched while the index already points to it, and receives writes once the enable is set. The key values let the bench drive near-miss unlock attempts: a wrong value, a byte probe instead of a word probe, and a word-sized key write.

// File: rtl/ide_cfgwin_pkg.sv
package ide_cfgwin_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ONE  = 2'd1,
    SEQ_TWO  = 2'd2
  } seq_e;

  localparam logic [2:0] OFS_RDTIM = 3'd0;
  localparam logic [2:0] OFS_WRTIM = 3'd1;
  localparam logic [2:0] OFS_PROBE = 3'd1;
  localparam logic [2:0] OFS_KEY   = 3'd2;
  localparam logic [2:0] OFS_CTRL  = 3'd3;
  localparam logic [2:0] OFS_STRAP = 3'd5;
  localparam logic [2:0] OFS_MISC  = 3'd6;

  // word read at the probe offset: one step of the unlock run
  function automatic logic is_probe(logic wr, logic word, logic [2:0] ofs);
    return !wr && word && (ofs == OFS_PROBE);
  endfunction

  // byte write of a given key value at the key offset
  function automatic logic is_key(logic wr, logic word, logic [2:0] ofs,
                                  logic [7:0] val, logic [7:0] key);
    return wr && !word && (ofs == OFS_KEY) && (val == key);
  endfunction

endpackage

// File: rtl/ide_cfgwin_seq.sv
module ide_cfgwin_seq
  import ide_cfgwin_pkg::*;
#(
  parameter logic [7:0] KEY_OPEN  = 8'h03,
  parameter logic [7:0] KEY_CLOSE = 8'h83
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic       acc_word,
  input  logic [2:0] acc_ofs,
  input  logic [7:0] acc_byte,
  output logic       win_open,
  output logic       open_evt,
  output logic       close_evt
);

  seq_e seq_q;
  logic win_q;
  logic probe_hit;

  assign probe_hit = acc_valid && is_probe(acc_write, acc_word, acc_ofs);
  assign open_evt  = acc_valid && !win_q && (seq_q == SEQ_TWO) &&
                     is_key(acc_write, acc_word, acc_ofs, acc_byte, KEY_OPEN);
  assign close_evt = acc_valid && win_q &&
                     is_key(acc_write, acc_word, acc_ofs, acc_byte, KEY_CLOSE);
  assign win_open  = win_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q <= SEQ_IDLE;
      win_q <= 1'b0;
    end else if (acc_valid) begin
      if (win_q) begin
        seq_q <= SEQ_IDLE;
        if (close_evt) win_q <= 1'b0;
      end else if (open_evt) begin
        win_q <= 1'b1;
        seq_q <= SEQ_IDLE;
      end else if (probe_hit) begin
        seq_q <= (seq_q == SEQ_IDLE) ? SEQ_ONE : SEQ_TWO;
      end else begin
        seq_q <= SEQ_IDLE;
      end
    end
  end

  // R2
  open_only_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(acc_valid && acc_write && !acc_word &&
                              acc_ofs == OFS_KEY && acc_byte == KEY_OPEN));

  // R4
  close_only_by_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(win_open) |-> $past(acc_valid && acc_write && !acc_word &&
                              acc_ofs == OFS_KEY && acc_byte == KEY_CLOSE));

endmodule

// File: rtl/ide_cfgwin_regs.sv
module ide_cfgwin_regs
  import ide_cfgwin_pkg::*;
#(
  parameter int          BANK_CNT = 2,
  parameter int          REG_W    = 8,
  parameter logic [7:0]  KEY_ALT  = 8'hC0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_valid,
  input  logic                      acc_write,
  input  logic [2:0]                acc_ofs,
  input  logic [REG_W-1:0]          acc_byte,
  input  logic                      win_open,
  output logic [BANK_CNT*REG_W-1:0] rd_timing,
  output logic [BANK_CNT*REG_W-1:0] wr_timing,
  output logic [REG_W-1:0]          ctrl_word,
  output logic [REG_W-1:0]          misc_word,
  output logic [REG_W-1:0]          rdata
);

  localparam int BSEL_W = (BANK_CNT > 1) ? $clog2(BANK_CNT) : 1;

  logic [REG_W-1:0]  rd_q [BANK_CNT];
  logic [REG_W-1:0]  wr_q [BANK_CNT];
  logic [REG_W-1:0]  ctrl_q, misc_q;
  logic [BSEL_W-1:0] bank_idx, eff_bank;
  logic              alt_en;
  logic              cfg_wr, alt_hit, idx_hit;

  assign cfg_wr   = acc_valid && acc_write && win_open;
  assign alt_hit  = acc_valid && acc_write && !win_open &&
                    (acc_ofs == OFS_CTRL) && (acc_byte[7:0] == KEY_ALT);
  assign idx_hit  = int'(acc_byte) < BANK_CNT;
  assign eff_bank = alt_en ? bank_idx : '0;

  genvar b;
  generate
    for (b = 0; b < BANK_CNT; b++) begin : g_bank
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          rd_q[b] <= '0;
          wr_q[b] <= '0;
        end else if (cfg_wr && eff_bank == BSEL_W'(b)) begin
          if (acc_ofs == OFS_RDTIM) rd_q[b] <= acc_byte;
          if (acc_ofs == OFS_WRTIM) wr_q[b] <= acc_byte;
        end
      end
      assign rd_timing[b*REG_W +: REG_W] = rd_q[b];
      assign wr_timing[b*REG_W +: REG_W] = wr_q[b];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      misc_q   <= '0;
      bank_idx <= '0;
      alt_en   <= 1'b0;
    end else begin
      if (alt_hit) alt_en <= 1'b1;
      if (cfg_wr && acc_ofs == OFS_CTRL) ctrl_q <= acc_byte;
      if (cfg_wr && acc_ofs == OFS_MISC) begin
        if (idx_hit) bank_idx <= acc_byte[BSEL_W-1:0];
        else         misc_q   <= acc_byte;
      end
    end
  end

  always_comb begin
    rdata = '1;
    if (win_open) begin
      case (acc_ofs)
        OFS_RDTIM: rdata = rd_q[eff_bank];
        OFS_WRTIM: rdata = wr_q[eff_bank];
        OFS_CTRL:  rdata = ctrl_q;
        OFS_STRAP: rdata = '0;
        OFS_MISC:  rdata = misc_q;
        default:   rdata = '1;
      endcase
    end
  end

  assign ctrl_word = ctrl_q;
  assign misc_word = misc_q;

  // R10
  closed_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> $stable(ctrl_q) && $stable(misc_q) &&
                  $stable(rd_timing) && $stable(wr_timing));

  // R9
  closed_read_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |-> rdata == '1);

  generate
    if (BANK_CNT > 1) begin : g_alt_chk
      // R7
      alt_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alt_en && acc_valid && acc_write) |=>
          $stable(rd_q[1]) && $stable(wr_q[1]));
    end
  endgenerate

endmodule

// File: rtl/ide_cfg_window.sv
module ide_cfg_window
  import ide_cfgwin_pkg::*;
#(
  parameter int         BANK_CNT  = 2,
  parameter int         REG_W     = 8,
  parameter logic [7:0] KEY_OPEN  = 8'h03,
  parameter logic [7:0] KEY_CLOSE = 8'h83,
  parameter logic [7:0] KEY_ALT   = 8'hC0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_valid,
  input  logic                      acc_write,
  input  logic                      acc_word,
  input  logic [2:0]                acc_ofs,
  input  logic [REG_W-1:0]          acc_wdata,
  output logic [REG_W-1:0]          acc_rdata,
  output logic                      cfg_steer,
  output logic [BANK_CNT*REG_W-1:0] rd_timing,
  output logic [BANK_CNT*REG_W-1:0] wr_timing,
  output logic [REG_W-1:0]          ctrl_word,
  output logic [REG_W-1:0]          misc_word
);

  logic win_open, open_evt, close_evt;

  ide_cfgwin_seq #(.KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_word  (acc_word),
    .acc_ofs   (acc_ofs),
    .acc_byte  (acc_wdata[7:0]),
    .win_open  (win_open),
    .open_evt  (open_evt),
    .close_evt (close_evt)
  );

  ide_cfgwin_regs #(.BANK_CNT(BANK_CNT), .REG_W(REG_W), .KEY_ALT(KEY_ALT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_ofs   (acc_ofs),
    .acc_byte  (acc_wdata),
    .win_open  (win_open),
    .rd_timing (rd_timing),
    .wr_timing (wr_timing),
    .ctrl_word (ctrl_word),
    .misc_word (misc_word),
    .rdata     (acc_rdata)
  );

  assign cfg_steer = win_open;

  // R2
  open_evt_sets_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    open_evt |=> cfg_steer);

  // R4
  close_evt_clears_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    close_evt |=> !cfg_steer);

endmodule

// File: tb/test_ide_cfg_window.sv
module test_ide_cfg_window;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0, acc_word = 1'b0;
  logic [2:0]  acc_ofs = '0;
  logic [7:0]  acc_wdata = '0;
  logic [7:0]  acc_rdata;
  logic        cfg_steer;
  logic [15:0] rd_timing, wr_timing;
  logic [7:0]  ctrl_word, misc_word;

  int n_checks = 0, n_err = 0;
  // reference model state
  int m_open = 0, m_run = 0, m_alt = 0, m_bank = 0, m_ctrl = 0, m_misc = 0;
  int m_rd[2] = '{0, 0};
  int m_wr[2] = '{0, 0};

  always #4 clk = ~clk;

  ide_cfg_window i_ide_cfg_window (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_word(acc_word), .acc_ofs(acc_ofs), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .cfg_steer(cfg_steer), .rd_timing(rd_timing),
    .wr_timing(wr_timing), .ctrl_word(ctrl_word), .misc_word(misc_word));

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int eb();
    return m_alt ? m_bank : 0;
  endfunction

  function automatic int model_read(int ofs);
    if (!m_open) return 255;
    case (ofs)
      0: return m_rd[eb()];
      1: return m_wr[eb()];
      3: return m_ctrl;
      5: return 0;
      6: return m_misc;
      default: return 255;
    endcase
  endfunction

  task automatic cmp_all(string tag);
    chk({tag, " steer"}, int'(cfg_steer), m_open);
    chk({tag, " rd_timing"}, int'(rd_timing), (m_rd[1] << 8) | m_rd[0]);
    chk({tag, " wr_timing"}, int'(wr_timing), (m_wr[1] << 8) | m_wr[0]);
    chk({tag, " ctrl"}, int'(ctrl_word), m_ctrl);
    chk({tag, " misc"}, int'(misc_word), m_misc);
  endtask

  // one access, issued at a falling edge; outputs compared one cycle later
  task automatic acc(bit wr, bit word, int ofs, int data, string tag);
    int v;
    v = data & 255;
    acc_valid = 1'b1; acc_write = wr; acc_word = word;
    acc_ofs = 3'(ofs); acc_wdata = 8'(v);
    #1;
    if (!wr) chk({tag, " rdata"}, int'(acc_rdata), model_read(ofs));
    if (m_open) begin
      if (wr) begin
        if (ofs == 2 && !word && v == 8'h83) m_open = 0;
        else if (ofs == 0) m_rd[eb()] = v;
        else if (ofs == 1) m_wr[eb()] = v;
        else if (ofs == 3) m_ctrl = v;
        else if (ofs == 6) begin
          if (v < 2) m_bank = v; else m_misc = v;
        end
      end
      m_run = 0;
    end else begin
      if (wr && ofs == 3 && v == 8'hC0) m_alt = 1;
      if (wr && !word && ofs == 2 && v == 3 && m_run >= 2) begin
        m_open = 1; m_run = 0;
      end else if (!wr && word && ofs == 1) m_run++;
      else m_run = 0;
    end
    @(posedge clk);
    @(negedge clk);
    acc_valid = 1'b0;
    cmp_all(tag);
  endtask

  task automatic unlock(string tag);
    acc(0, 1, 1, 0, tag);
    acc(0, 1, 1, 0, tag);
    acc(1, 0, 2, 8'h03, tag);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_all("R1 reset");

    // closed: reads give FF, writes ignored
    acc(0, 0, 0, 0, "R9 closed read");
    acc(1, 0, 0, 8'h55, "R10 closed write rd");
    acc(1, 0, 3, 8'h12, "R10 closed write ctrl");
    acc(1, 0, 6, 8'h44, "R10 closed write misc");

    // broken unlock runs
    acc(0, 1, 1, 0, "R3"); acc(0, 0, 1, 0, "R3 byte probe");
    acc(0, 1, 1, 0, "R3"); acc(1, 0, 2, 8'h03, "R3 one probe only");
    acc(0, 1, 1, 0, "R3"); acc(0, 1, 2, 0, "R3 other ofs"); acc(0, 1, 1, 0, "R3");
    acc(1, 0, 2, 8'h03, "R3 gap");
    acc(0, 1, 1, 0, "R3"); acc(0, 1, 1, 0, "R3"); acc(1, 0, 2, 8'h04, "R3 wrong value");
    acc(1, 0, 2, 8'h03, "R3 after wrong value");
    acc(0, 1, 1, 0, "R3"); acc(0, 1, 1, 0, "R3"); acc(1, 1, 2, 8'h03, "R3 word key");

    // open with three probes
    acc(0, 1, 1, 0, "R2"); acc(0, 1, 1, 0, "R2"); acc(0, 1, 1, 0, "R2");
    acc(1, 0, 2, 8'h03, "R2 open");

    acc(1, 0, 0, 8'h21, "R5 rd timing");
    acc(1, 0, 1, 8'h34, "R5 wr timing");
    acc(0, 0, 0, 0, "R5 read rd");
    acc(0, 1, 1, 0, "R5 read wr");
    acc(1, 0, 6, 8'h01, "R6 select B");
    acc(1, 0, 0, 8'h77, "R7 B disabled");
    acc(0, 0, 0, 0, "R7 read A");
    acc(1, 0, 3, 8'h85, "R5 ctrl");
    acc(0, 0, 3, 0, "R5 ctrl read");
    acc(1, 0, 6, 8'h40, "R6 misc");
    acc(0, 0, 6, 0, "R6 misc read");
    acc(1, 0, 5, 8'h12, "R8 strap write");
    acc(0, 0, 5, 0, "R8 strap read");
    acc(0, 0, 2, 0, "R9 ofs2");
    acc(0, 0, 4, 0, "R9 ofs4");
    acc(0, 0, 7, 0, "R9 ofs7");
    acc(1, 0, 2, 8'h11, "R4 other key");
    acc(1, 1, 2, 8'h83, "R4 word close");
    acc(1, 0, 2, 8'h83, "R4 close");
    acc(0, 0, 0, 0, "R9 after close");

    // enable bank B from outside the window
    acc(1, 0, 3, 8'hC0, "R7 enable");
    unlock("R2 reopen");
    acc(1, 0, 0, 8'h9A, "R7 rd B");
    acc(1, 0, 1, 8'hBC, "R7 wr B");
    acc(0, 0, 0, 0, "R7 read B");
    acc(1, 0, 6, 8'h00, "R6 select A");
    acc(0, 0, 0, 0, "R6 read A");
    acc(0, 1, 1, 0, "R6 read A wr");
    acc(1, 0, 6, 8'h01, "R6 select B again");
    acc(0, 1, 1, 0, "R6 read B wr");
    acc(1, 0, 2, 8'h83, "R4 close again");
    acc(1, 0, 1, 8'h66, "R10 closed after");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule